// File: doc/BRIEF.md
# Codec Control-Link Sequencer with Status Mirror

This block sits between a host controller and the control port of an audio sub-band codec. On each frame-sync pulse it reads the codec status word. In encoding mode it then sends the frame's allocation units to the codec. The first unit goes out at once. Before each further unit the block polls the codec status until the codec reports it is ready to receive. After the last unit it writes the settings word, then the scale-factor index words when the scale-select input is low.

The host sees a continuous copy of the last codec status word. In that copy the codec's ready bit and the spare bit beside it are replaced by two local flags. One says the block can take a new settings word, the other says it can take a new extended settings word. Extended settings are sent to the codec at the first idle slot. In decoding mode the block only performs the frame status reads. Allocation units and scale words come from FIFO-like sources with valid/pop handshakes. The codec port is word-level: a request is held until the codec acknowledges it.

Top module: `codec_link_seq`

## Requirements
- R1: After reset no codec request is raised and host_status reads 16'h0C00 (both local flags set, mirrored status cleared).
- R2: After a frame-sync pulse, the first codec transaction is a status read (cod_kind 0), even when extended settings are waiting in the same cycle.
- R3: In encoding mode, the first allocation write (cod_kind 1) directly follows the frame status read, with no poll in between.
- R4: Each further allocation unit is preceded by one or more status reads. The unit is sent only after a read returns bit 10 set. A read with bit 10 clear is repeated. A frame carries ALLOC_UNITS units in source order.
- R5: After the last allocation unit, the settings word held from the host is written with cod_kind 2.
- R6: After the settings write, SF_WORDS scale words (cod_kind 3) are sent in source order only if scale_sel is low. When scale_sel is high, none are sent.
- R7: host_status equals the last codec status read, with bit 10 replaced by the settings flag S and bit 11 by the extended flag E.
- R8: A settings write from the host is taken only while S is 1. Taking it clears S. S sets again once that word has gone to the codec. A write while S is 0 is ignored.
- R9: An extended settings write is taken only while E is 1 and clears E. A write while E is 0 is ignored.
- R10: A taken extended word is written to the codec (cod_kind 4) at the first idle slot after any pending frame sequence, and E then sets again.
- R11: With dec_mode high, the only codec transactions are status reads. Extended settings are not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| frame_sync | input | 1 | one-cycle frame start pulse |
| dec_mode | input | 1 | 1 = decoding mode, 0 = encoding mode |
| scale_sel | input | 1 | 0 = send scale words after settings |
| alloc_valid | input | 1 | allocation unit available |
| alloc_data | input | W | allocation unit |
| alloc_pop | output | 1 | allocation unit consumed |
| sf_valid | input | 1 | scale word available |
| sf_data | input | W | scale word |
| sf_pop | output | 1 | scale word consumed |
| host_set_wr | input | 1 | host settings write strobe |
| host_set_data | input | W | host settings word |
| host_ext_wr | input | 1 | host extended settings write strobe |
| host_ext_data | input | W | host extended settings word |
| host_status | output | W | mirrored status with local flags |
| cod_req | output | 1 | codec transaction request |
| cod_kind | output | 3 | 0 read, 1 alloc, 2 settings, 3 scale, 4 extended |
| cod_wdata | output | W | codec write word |
| cod_ack | input | 1 | codec transaction complete |
| cod_rdata | input | W | codec status word, valid with ack of a read |

## Verification
The assertions assume the codec never acknowledges a request that is not raised. They also assume dec_mode changes only under reset, scale_sel stays steady through a frame, and the allocation and scale sources keep valid high once a transfer starts. The bench's codec model acknowledges every second cycle, and only while a request is up. The bench switches mode only inside a reset pulse, sets scale_sel between frames, and keeps both sources valid at all times. Ready patterns for the polled status are swept arithmetically, so that frames see anything from no waiting to repeated not-ready reads.

// File: rtl/codec_link_seq.sv
module codec_link_seq #(
  parameter int W           = 16,
  parameter int ALLOC_UNITS = 8,
  parameter int SF_WORDS    = 4,
  parameter int RDY_BIT     = 10,
  parameter int E_BIT       = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frame_sync,
  input  logic         dec_mode,
  input  logic         scale_sel,
  input  logic         alloc_valid,
  input  logic [W-1:0] alloc_data,
  output logic         alloc_pop,
  input  logic         sf_valid,
  input  logic [W-1:0] sf_data,
  output logic         sf_pop,
  input  logic         host_set_wr,
  input  logic [W-1:0] host_set_data,
  input  logic         host_ext_wr,
  input  logic [W-1:0] host_ext_data,
  output logic [W-1:0] host_status,
  output logic         cod_req,
  output logic [2:0]   cod_kind,
  output logic [W-1:0] cod_wdata,
  input  logic         cod_ack,
  input  logic [W-1:0] cod_rdata
);
  localparam int MAXC = (ALLOC_UNITS > SF_WORDS) ? ALLOC_UNITS : SF_WORDS;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [2:0] K_RD = 3'd0, K_AL = 3'd1, K_SET = 3'd2, K_SF = 3'd3, K_EXT = 3'd4;

  typedef enum logic [2:0] {IDLE, ST_RD, AL_WR, POLL, SET_WR, SF_WR, EXT_WR} st_t;
  st_t st;

  logic [W-1:0]  stat, set_reg, ext_reg;
  logic [CW-1:0] cnt;
  logic          s_flag, e_flag, fs_pend, ext_pend, done, last_al, last_sf, go_rd;

  assign cod_req = (st == ST_RD) || (st == POLL) || (st == SET_WR) || (st == EXT_WR)
                || (st == AL_WR && alloc_valid) || (st == SF_WR && sf_valid);
  assign done      = cod_req && cod_ack;
  assign last_al   = cnt == CW'(ALLOC_UNITS - 1);
  assign last_sf   = cnt == CW'(SF_WORDS - 1);
  assign alloc_pop = done && st == AL_WR;
  assign sf_pop    = done && st == SF_WR;
  assign go_rd     = st == IDLE && fs_pend;

  always_comb begin
    cod_kind  = K_RD;
    cod_wdata = '0;
    case (st)
      AL_WR:  begin cod_kind = K_AL;  cod_wdata = alloc_data; end
      SET_WR: begin cod_kind = K_SET; cod_wdata = set_reg;    end
      SF_WR:  begin cod_kind = K_SF;  cod_wdata = sf_data;    end
      EXT_WR: begin cod_kind = K_EXT; cod_wdata = ext_reg;    end
      default: ;
    endcase
    host_status          = stat;
    host_status[RDY_BIT] = s_flag;
    host_status[E_BIT]   = e_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= IDLE; cnt <= '0; stat <= '0; set_reg <= '0; ext_reg <= '0;
      s_flag <= 1'b1; e_flag <= 1'b1; fs_pend <= 1'b0; ext_pend <= 1'b0;
    end else begin
      fs_pend <= frame_sync || (fs_pend && !go_rd);
      case (st)
        IDLE:
          if (fs_pend) st <= ST_RD;
          else if (ext_pend && !dec_mode) st <= EXT_WR;
        ST_RD:
          if (done) begin
            stat <= cod_rdata;
            cnt  <= '0;
            st   <= dec_mode ? IDLE : AL_WR;
          end
        AL_WR:
          if (done) begin
            cnt <= cnt + 1'b1;
            st  <= last_al ? SET_WR : POLL;
          end
        POLL:
          if (done) begin
            stat <= cod_rdata;
            if (cod_rdata[RDY_BIT]) st <= AL_WR;
          end
        SET_WR:
          if (done) begin
            s_flag <= 1'b1;
            cnt    <= '0;
            st     <= scale_sel ? IDLE : SF_WR;
          end
        SF_WR:
          if (done) begin
            cnt <= cnt + 1'b1;
            if (last_sf) st <= IDLE;
          end
        EXT_WR:
          if (done) begin
            ext_pend <= 1'b0;
            e_flag   <= 1'b1;
            st       <= IDLE;
          end
        default: st <= IDLE;
      endcase
      if (host_set_wr && s_flag) begin
        set_reg <= host_set_data;
        s_flag  <= 1'b0;
      end
      if (host_ext_wr && e_flag) begin
        ext_reg  <= host_ext_data;
        ext_pend <= 1'b1;
        e_flag   <= 1'b0;
      end
    end
  end

  p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
    cod_req && !cod_ack && cod_kind != K_AL && cod_kind != K_SF |=> cod_req && $stable(cod_kind));
  p_alloc_spaced_r4: assert property (@(posedge clk) disable iff (rst)
    cod_req && cod_ack && cod_kind == K_AL |=> cod_kind != K_AL);
  p_first_read_r2: assert property (@(posedge clk) disable iff (rst)
    $past(go_rd) |-> cod_kind == K_RD && cod_req);
  p_set_clear_r8: assert property (@(posedge clk) disable iff (rst)
    host_set_wr && !host_status[RDY_BIT] |=> $stable(set_reg));
  p_ext_clear_r9: assert property (@(posedge clk) disable iff (rst)
    host_ext_wr && host_status[E_BIT] |=> !host_status[E_BIT]);
  p_dec_reads_r11: assert property (@(posedge clk) disable iff (rst)
    dec_mode && cod_req |-> cod_kind == K_RD);
  p_scale_gate_r6: assert property (@(posedge clk) disable iff (rst)
    sf_pop |-> !scale_sel && !alloc_pop);
endmodule

// File: tb/tb_codec_link_seq.sv
module tb_codec_link_seq;
  localparam int PER = 10;
  localparam int W = 16, NA = 8, NS = 4;

  logic clk = 0, rst = 1, frame_sync = 0, dec_mode = 0, scale_sel = 0;
  logic alloc_pop, sf_pop, host_set_wr = 0, host_ext_wr = 0, cod_req, cod_ack = 0;
  logic [W-1:0] host_set_data = '0, host_ext_data = '0, host_status, cod_wdata, cod_rdata;
  logic [2:0] cod_kind;
  logic [W-1:0] alloc_data, sf_data;

  int checks = 0, failures = 0;
  int ai = 0, si = 0, rd_cnt = 0, log_n = 0;
  int cur_pm = 1;
  logic [9:0] cur_base = '0;
  logic [2:0] log_k [1024];
  logic [W-1:0] log_d [1024];
  logic [2:0] ek [128];
  logic [W-1:0] ed [128];
  int e_n;

  always #(PER/2) clk = ~clk;

  assign alloc_data = 16'hA000 + W'(ai);
  assign sf_data    = 16'h5000 + W'(si);
  assign cod_rdata  = {5'b0, ((rd_cnt % cur_pm) != 1), cur_base};

  codec_link_seq #(.W(W), .ALLOC_UNITS(NA), .SF_WORDS(NS)) dut (
    .clk(clk), .rst(rst), .frame_sync(frame_sync), .dec_mode(dec_mode), .scale_sel(scale_sel),
    .alloc_valid(1'b1), .alloc_data(alloc_data), .alloc_pop(alloc_pop),
    .sf_valid(1'b1), .sf_data(sf_data), .sf_pop(sf_pop),
    .host_set_wr(host_set_wr), .host_set_data(host_set_data),
    .host_ext_wr(host_ext_wr), .host_ext_data(host_ext_data), .host_status(host_status),
    .cod_req(cod_req), .cod_kind(cod_kind), .cod_wdata(cod_wdata),
    .cod_ack(cod_ack), .cod_rdata(cod_rdata));

  always @(posedge clk) begin
    cod_ack <= cod_req && !cod_ack;
    if (cod_req && cod_ack) begin
      log_k[log_n] <= cod_kind;
      log_d[log_n] <= cod_wdata;
      log_n <= log_n + 1;
      if (cod_kind == 3'd0) rd_cnt <= rd_cnt + 1;
    end
    if (alloc_pop) ai <= ai + 1;
    if (sf_pop) si <= si + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] k, input logic [W-1:0] d);
    ek[e_n] = k; ed[e_n] = d; e_n++;
  endtask

  task automatic build_frame(input bit sc, input logic [W-1:0] setw, inout int eai, inout int esi);
    int r;
    bit rdy;
    r = rd_cnt;
    push(3'd0, '0); r++;
    push(3'd1, 16'hA000 + W'(eai)); eai++;
    for (int u = 1; u < NA; u++) begin
      do begin
        push(3'd0, '0);
        rdy = (r % cur_pm) != 1;
        r++;
      end while (!rdy);
      push(3'd1, 16'hA000 + W'(eai)); eai++;
    end
    push(3'd2, setw);
    if (!sc)
      for (int k = 0; k < NS; k++) begin push(3'd3, 16'h5000 + W'(esi)); esi++; end
  endtask

  task automatic wait_compare(input int start, input string req);
    for (int t = 0; t < 3000 && log_n < start + e_n; t++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(log_n == start + e_n, req, log_n - start, e_n);
    for (int i = 0; i < e_n && i < log_n - start; i++) begin
      chk(log_k[start+i] == ek[i], req, int'(log_k[start+i]), int'(ek[i]));
      if (ek[i] != 3'd0) chk(log_d[start+i] == ed[i], req, int'(log_d[start+i]), int'(ed[i]));
    end
  endtask

  task automatic pulse_fs();
    frame_sync = 1; @(negedge clk); frame_sync = 0;
  endtask

  initial begin
    #(PER * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int eai, esi, start;
    logic [W-1:0] setw;
    eai = 0; esi = 0; setw = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(host_status == 16'h0C00, "R1", int'(host_status), 16'h0C00);
    chk(cod_req == 0, "R1", int'(cod_req), 0);

    // R3 R4 R5 R6 R7: sweep scale select and ready patterns
    for (int sc = 0; sc < 2; sc++)
      for (int pm = 1; pm <= 3; pm++) begin
        scale_sel = sc[0]; cur_pm = pm; cur_base = 10'(37 * (sc * 3 + pm) + 5);
        @(negedge clk);
        e_n = 0; start = log_n;
        build_frame(sc[0], setw, eai, esi);
        pulse_fs();
        wait_compare(start, "R4");
        chk(host_status == {4'b0, 2'b11, cur_base}, "R7", int'(host_status), int'({4'b0, 2'b11, cur_base}));
      end

    // R8: take one settings word, ignore the second
    scale_sel = 0; cur_pm = 2; cur_base = 10'h155;
    host_set_wr = 1; host_set_data = 16'h1234; @(negedge clk);
    chk(host_status[10] == 0, "R8", int'(host_status[10]), 0);
    host_set_data = 16'h9999; @(negedge clk);
    host_set_wr = 0;
    setw = 16'h1234;
    e_n = 0; start = log_n;
    build_frame(1'b0, setw, eai, esi);
    pulse_fs();
    wait_compare(start, "R8");
    chk(host_status[10] == 1, "R8", int'(host_status[10]), 1);

    // R9 R10: extended word forwarded when idle, second write ignored
    e_n = 0; start = log_n;
    host_ext_wr = 1; host_ext_data = 16'h0E01; @(negedge clk);
    chk(host_status[11] == 0, "R9", int'(host_status[11]), 0);
    host_ext_data = 16'h0E02; @(negedge clk);
    host_ext_wr = 0;
    push(3'd4, 16'h0E01);
    wait_compare(start, "R10");
    chk(host_status[11] == 1, "R10", int'(host_status[11]), 1);

    // R2 R10: frame sync and extended write in the same cycle
    scale_sel = 1; cur_pm = 3;
    @(negedge clk);
    e_n = 0; start = log_n;
    build_frame(1'b1, setw, eai, esi);
    push(3'd4, 16'h0E07);
    host_ext_wr = 1; host_ext_data = 16'h0E07; frame_sync = 1;
    @(negedge clk);
    host_ext_wr = 0; frame_sync = 0;
    wait_compare(start, "R2");

    // R11: decoding mode issues only status reads
    rst = 1; dec_mode = 1; repeat (2) @(negedge clk); rst = 0;
    @(negedge clk);
    e_n = 0; start = log_n;
    push(3'd0, '0);
    host_ext_wr = 1; host_ext_data = 16'h0E09; frame_sync = 1;
    @(negedge clk);
    host_ext_wr = 0; frame_sync = 0;
    wait_compare(start, "R11");
    chk(host_status[11] == 0, "R11", int'(host_status[11]), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule